// File: doc/BRIEF.md
# Dual-Loop Digital Lock Detector

This block decides whether two phase-locked loops, a high-frequency RF loop and a lower-frequency IF loop, are in lock. It observes the up and down pulses of each loop's phase-frequency detector and passes them through a two-stage synchronizer. It then measures, in ticks of a sampling clock, how long each phase-error pulse lasts. Each loop has its own pair of programmable thresholds. A pulse as long as the upper threshold drops the loop out of lock at once. The loop regains lock only after a set run of comparison cycles in which the widest pulse stays at or below the lower threshold. That run is ten cycles for the RF loop and three for the IF loop. Widths that fall between the two thresholds form a hysteresis band.

Each loop supplies a comparison strobe that marks the end of one comparison period. A loop in power save counts as locked and keeps its internal state frozen. The combined lock signal is driven on a single monitor pin. A monitor enable can instead route one of four divided reference or feedback signals to that pin.

Top module: `dual_lock_detect`

## Requirements
- R1: After reset, and after any later reset, both loops are unlocked and their good-cycle runs are empty, so `rf_ok`, `if_ok`, `lock_all` and `mon_pin` (with `mon_en` low) are 0. The IF loop then needs a full three good cycles to lock.
- R2: A loop drops to unlocked as soon as the synchronized error (up OR down) has been high for `unlock_thr` consecutive sampling ticks. This happens without waiting for a strobe, and it clears the good-cycle run. A pulse driven for `k` clock periods starting at a falling edge makes the loop's `*_ok` low after the (k+2)th following rising edge.
- R3: The RF loop locks at the strobe that closes the 10th consecutive comparison cycle whose widest pulse is at most `rf_lock_thr` ticks. It is still unlocked after the 9th such cycle. A pulse exactly equal to the threshold counts as good.
- R4: The IF loop locks at the strobe closing the 3rd consecutive good cycle, judged against `if_lock_thr`. It is not locked after the 2nd.
- R5: A comparison cycle whose widest pulse is above the lock threshold but below the unlock threshold leaves the lock state unchanged and empties the good-cycle run.
- R6: `lock_all` is 1 exactly when each loop is either locked or in power save.
- R7: While a loop's power-save input is 1, its `*_ok` output is 1. Its pulses and strobes are ignored, so on leaving power save the loop shows the same lock state it had on entry.
- R8: With `mon_en` = 0, `mon_pin` carries `lock_all`. With `mon_en` = 1, `mon_sel` selects the signal: 2'b00 IF reference, 2'b01 RF reference, 2'b10 IF feedback, 2'b11 RF feedback. Bit 0 picks RF over IF; bit 1 picks feedback over reference.
- R9: Up pulses and down pulses are measured the same way on both loops, so a wide down pulse unlocks just as a wide up pulse does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_up | input | 1 | RF detector up pulse (asynchronous) |
| rf_dn | input | 1 | RF detector down pulse (asynchronous) |
| if_up | input | 1 | IF detector up pulse (asynchronous) |
| if_dn | input | 1 | IF detector down pulse (asynchronous) |
| rf_stb | input | 1 | One-tick strobe ending an RF comparison cycle |
| if_stb | input | 1 | One-tick strobe ending an IF comparison cycle |
| rf_ps | input | 1 | RF loop power save |
| if_ps | input | 1 | IF loop power save |
| rf_unlock_thr | input | THR_W | RF unlock width in ticks |
| rf_lock_thr | input | THR_W | RF lock width in ticks |
| if_unlock_thr | input | THR_W | IF unlock width in ticks |
| if_lock_thr | input | THR_W | IF lock width in ticks |
| mon_en | input | 1 | Route a monitor signal instead of the lock signal |
| mon_sel | input | 2 | Monitor signal selection |
| if_ref | input | 1 | Divided IF reference |
| rf_ref | input | 1 | Divided RF reference |
| if_fb | input | 1 | Divided IF feedback |
| rf_fb | input | 1 | Divided RF feedback |
| rf_ok | output | 1 | RF loop locked or in power save |
| if_ok | output | 1 | IF loop locked or in power save |
| lock_all | output | 1 | Both loops locked or in power save |
| mon_pin | output | 1 | Monitor pin |

## Verification
The hardest case to reach is the proof that power save really freezes a loop. While the loop is in power save its output is forced high, so the frozen state cannot be seen at the ports. The stimulus therefore enters power save with each loop in a known state: RF unlocked, IF locked. It drives a full run of good cycles into RF and a wide error into IF, then leaves power save and reads back the unchanged states. A second hard case is showing that a mid-band error clears the good-cycle run. For this the stimulus inserts such a cycle after five good ones and confirms that lock then takes a further ten good cycles.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
package lockdet_pkg;
   // monitor pin routing: bit 0 = RF side, bit 1 = feedback side
   typedef enum logic [1:0] {
      MON_IF_REF = 2'b00,
      MON_RF_REF = 2'b01,
      MON_IF_FB  = 2'b10,
      MON_RF_FB  = 2'b11
   } mon_sel_e;
endpackage

// File: rtl/lockdet_sync.sv
`timescale 1ns/1ps
module lockdet_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lockdet_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= {stage_q[STAGES-2:0], d};
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lockdet_loop.sv
`timescale 1ns/1ps
module lockdet_loop #(
   parameter int THR_W       = 8,
   parameter int GOOD_N      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             dn,
   input  logic             stb,
   input  logic             pwr_save,
   input  logic [THR_W-1:0] unlock_thr,
   input  logic [THR_W-1:0] lock_thr,
   output logic             locked,
   output logic             ok,
   output logic             err
);
   localparam int               GOOD_W    = $clog2(GOOD_N + 1);
   localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_N - 1);
   localparam logic [THR_W-1:0]  WIDTH_MAX = '1;

   generate
      if (GOOD_N < 1) begin : g_bad_good
         $error("lockdet_loop: GOOD_N must be at least 1");
      end
   endgenerate

   logic [1:0]        pd_s;
   logic [THR_W-1:0]  width_q, peak_q, cur_w, peak_n;
   logic [GOOD_W-1:0] good_q;
   logic              wide_err, quiet;

   lockdet_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({up, dn}),
      .q     (pd_s)
   );

   // width of the running error pulse including this tick, saturating
   always_comb begin
      err = pd_s[1] | pd_s[0];
      if (!err)                   cur_w = '0;
      else if (width_q == WIDTH_MAX) cur_w = WIDTH_MAX;
      else                        cur_w = width_q + 1'b1;
      peak_n   = (cur_w > peak_q) ? cur_w : peak_q;
      wide_err = err && (cur_w >= unlock_thr);
      quiet    = (peak_n <= lock_thr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q <= '0;
         peak_q  <= '0;
         good_q  <= '0;
         locked  <= 1'b0;
      end else if (pwr_save) begin
         width_q <= '0;
         peak_q  <= '0;
      end else begin
         width_q <= cur_w;
         peak_q  <= stb ? '0 : peak_n;
         if (wide_err) begin
            locked <= 1'b0;
            good_q <= '0;
         end else if (stb) begin
            if (!quiet)                 good_q <= '0;
            else if (good_q == GOOD_LAST) locked <= 1'b1;
            else                        good_q <= good_q + 1'b1;
         end
      end
   end

   assign ok = locked | pwr_save;
endmodule

// File: rtl/lockdet_mon.sv
`timescale 1ns/1ps
module lockdet_mon
   import lockdet_pkg::*;
(
   input  logic       lock_all,
   input  logic       mon_en,
   input  logic [1:0] mon_sel,
   input  logic       if_ref,
   input  logic       rf_ref,
   input  logic       if_fb,
   input  logic       rf_fb,
   output logic       mon_pin
);
   always_comb begin
      if (!mon_en) mon_pin = lock_all;
      else begin
         unique case (mon_sel_e'(mon_sel))
            MON_IF_REF: mon_pin = if_ref;
            MON_RF_REF: mon_pin = rf_ref;
            MON_IF_FB:  mon_pin = if_fb;
            MON_RF_FB:  mon_pin = rf_fb;
         endcase
      end
   end
endmodule

// File: rtl/dual_lock_detect.sv
`timescale 1ns/1ps
module dual_lock_detect #(
   parameter int THR_W       = 8,
   parameter int RF_GOOD_N   = 10,
   parameter int IF_GOOD_N   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rf_up,
   input  logic             rf_dn,
   input  logic             if_up,
   input  logic             if_dn,
   input  logic             rf_stb,
   input  logic             if_stb,
   input  logic             rf_ps,
   input  logic             if_ps,
   input  logic [THR_W-1:0] rf_unlock_thr,
   input  logic [THR_W-1:0] rf_lock_thr,
   input  logic [THR_W-1:0] if_unlock_thr,
   input  logic [THR_W-1:0] if_lock_thr,
   input  logic             mon_en,
   input  logic [1:0]       mon_sel,
   input  logic             if_ref,
   input  logic             rf_ref,
   input  logic             if_fb,
   input  logic             rf_fb,
   output logic             rf_ok,
   output logic             if_ok,
   output logic             lock_all,
   output logic             mon_pin
);
   generate
      if (THR_W < 2) begin : g_bad_thr
         $error("dual_lock_detect: THR_W must be at least 2");
      end
   endgenerate

   logic rf_state, if_state, rf_err, if_err;

   lockdet_loop #(.THR_W(THR_W), .GOOD_N(RF_GOOD_N), .SYNC_STAGES(SYNC_STAGES)) u_rf (
      .clk(clk), .rst_n(rst_n), .up(rf_up), .dn(rf_dn), .stb(rf_stb), .pwr_save(rf_ps),
      .unlock_thr(rf_unlock_thr), .lock_thr(rf_lock_thr),
      .locked(rf_state), .ok(rf_ok), .err(rf_err)
   );

   lockdet_loop #(.THR_W(THR_W), .GOOD_N(IF_GOOD_N), .SYNC_STAGES(SYNC_STAGES)) u_if (
      .clk(clk), .rst_n(rst_n), .up(if_up), .dn(if_dn), .stb(if_stb), .pwr_save(if_ps),
      .unlock_thr(if_unlock_thr), .lock_thr(if_lock_thr),
      .locked(if_state), .ok(if_ok), .err(if_err)
   );

   assign lock_all = rf_ok & if_ok;

   lockdet_mon u_mon (
      .lock_all(lock_all), .mon_en(mon_en), .mon_sel(mon_sel),
      .if_ref(if_ref), .rf_ref(rf_ref), .if_fb(if_fb), .rf_fb(rf_fb),
      .mon_pin(mon_pin)
   );
endmodule

// File: rtl/lockdet_checker.sv
`timescale 1ns/1ps
module lockdet_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rf_state,
   input logic       if_state,
   input logic       rf_err,
   input logic       if_err,
   input logic       rf_stb,
   input logic       if_stb,
   input logic       rf_ps,
   input logic       if_ps,
   input logic       rf_ok,
   input logic       if_ok,
   input logic       lock_all,
   input logic       mon_en,
   input logic [1:0] mon_sel,
   input logic       mon_pin,
   input logic       rf_fb
);
   AST_RF_PS_OK:      assert property (@(posedge clk) disable iff (!rst_n) rf_ps |-> rf_ok); // R7
   AST_IF_PS_OK:      assert property (@(posedge clk) disable iff (!rst_n) if_ps |-> if_ok); // R7
   AST_RF_PS_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) $past(rf_ps) |-> $stable(rf_state)); // R7
   AST_IF_PS_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) $past(if_ps) |-> $stable(if_state)); // R7
   AST_RF_RISE_STB:   assert property (@(posedge clk) disable iff (!rst_n) $rose(rf_state) |-> $past(rf_stb)); // R3
   AST_IF_RISE_STB:   assert property (@(posedge clk) disable iff (!rst_n) $rose(if_state) |-> $past(if_stb)); // R4
   AST_RF_FALL_ERR:   assert property (@(posedge clk) disable iff (!rst_n) $fell(rf_state) |-> $past(rf_err)); // R2
   AST_IF_FALL_ERR:   assert property (@(posedge clk) disable iff (!rst_n) $fell(if_state) |-> $past(if_err)); // R2
   AST_ALL_BOTH:      assert property (@(posedge clk) disable iff (!rst_n) lock_all |-> (rf_ok && if_ok)); // R6
   AST_PIN_LOCK:      assert property (@(posedge clk) disable iff (!rst_n) !mon_en |-> (mon_pin == lock_all)); // R8
   AST_PIN_RF_FB:     assert property (@(posedge clk) disable iff (!rst_n) (mon_en && mon_sel == 2'b11) |-> (mon_pin == rf_fb)); // R8
endmodule

bind dual_lock_detect lockdet_checker u_chk (
   .clk(clk), .rst_n(rst_n), .rf_state(rf_state), .if_state(if_state),
   .rf_err(rf_err), .if_err(if_err), .rf_stb(rf_stb), .if_stb(if_stb),
   .rf_ps(rf_ps), .if_ps(if_ps), .rf_ok(rf_ok), .if_ok(if_ok),
   .lock_all(lock_all), .mon_en(mon_en), .mon_sel(mon_sel),
   .mon_pin(mon_pin), .rf_fb(rf_fb)
);

// File: tb/dual_lock_detect_test.sv
`timescale 1ns/1ps
module dual_lock_detect_test;
   localparam int RF_UL = 6, RF_LK = 3, IF_UL = 4, IF_LK = 2;
   localparam int RF_N = 10, IF_N = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rf_up = 0, rf_dn = 0, if_up = 0, if_dn = 0, rf_stb = 0, if_stb = 0;
   logic rf_ps = 0, if_ps = 0, mon_en = 0;
   logic [1:0] mon_sel = 2'b00;
   logic if_ref = 0, rf_ref = 0, if_fb = 0, rf_fb = 0;
   logic rf_ok, if_ok, lock_all, mon_pin;

   int checks = 0, errors = 0;
   bit done = 0;
   int rf_lk = 0, rf_gd = 0, if_lk = 0, if_gd = 0;

   typedef struct {
      logic  rf_ok, if_ok, all;
      string req;
   } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;   // 125 MHz

   dual_lock_detect uut (
      .clk(clk), .rst_n(rst_n), .rf_up(rf_up), .rf_dn(rf_dn), .if_up(if_up), .if_dn(if_dn),
      .rf_stb(rf_stb), .if_stb(if_stb), .rf_ps(rf_ps), .if_ps(if_ps),
      .rf_unlock_thr(8'(RF_UL)), .rf_lock_thr(8'(RF_LK)),
      .if_unlock_thr(8'(IF_UL)), .if_lock_thr(8'(IF_LK)),
      .mon_en(mon_en), .mon_sel(mon_sel), .if_ref(if_ref), .rf_ref(rf_ref),
      .if_fb(if_fb), .rf_fb(rf_fb),
      .rf_ok(rf_ok), .if_ok(if_ok), .lock_all(lock_all), .mon_pin(mon_pin)
   );

   task automatic chk(input logic got, input logic exp, input string req, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
      end
   endtask

   // reference model of one loop for one comparison cycle
   task automatic model(inout int lk, inout int gd, input int w, input int ul, input int lt,
                        input int n, input bit ps);
      if (ps) return;
      if (w >= ul) begin lk = 0; gd = 0; end
      else if (w > lt) gd = 0;
      else if (gd == n - 1) lk = 1;
      else gd++;
   endtask

   task automatic push(input string req);
      exp_t e;
      e.rf_ok = (rf_lk != 0) || rf_ps;
      e.if_ok = (if_lk != 0) || if_ps;
      e.all   = e.rf_ok && e.if_ok;
      e.req   = req;
      exp_q.push_back(e);
      repeat (2) @(negedge clk);
   endtask

   // driver: one comparison cycle on both loops; swap moves RF to dn and IF to up
   task automatic run_cycle(input int rw, input int iw, input bit swap, input string req);
      int span;
      span = (rw > iw) ? rw : iw;
      for (int k = 0; k < span; k++) begin
         if (swap) begin rf_dn = (k < rw); if_up = (k < iw); end
         else      begin rf_up = (k < rw); if_dn = (k < iw); end
         @(negedge clk);
      end
      rf_up = 0; rf_dn = 0; if_up = 0; if_dn = 0;
      repeat (4) @(negedge clk);
      rf_stb = 1; if_stb = 1;
      @(negedge clk);
      rf_stb = 0; if_stb = 0;
      repeat (3) @(negedge clk);
      model(rf_lk, rf_gd, rw, RF_UL, RF_LK, RF_N, rf_ps);
      model(if_lk, if_gd, iw, IF_UL, IF_LK, IF_N, if_ps);
      push(req);
   endtask

   // monitor: pops expectations and compares against the ports
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(rf_ok, e.rf_ok, e.req, "rf_ok");
         chk(if_ok, e.if_ok, e.req, "if_ok");
         chk(lock_all, e.all, {e.req, " R6"}, "lock_all");
         if (!mon_en) chk(mon_pin, e.all, {e.req, " R8"}, "mon_pin");
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rf_ok, 0, "R1", "rf_ok at reset");
      chk(if_ok, 0, "R1", "if_ok at reset");
      chk(lock_all, 0, "R1", "lock_all at reset");
      chk(mon_pin, 0, "R1", "mon_pin at reset");
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R3 R4: acquisition, with threshold-equal widths counted as good
      for (int c = 1; c <= 10; c++)
         run_cycle((c == 4) ? RF_LK : 2, (c == 2) ? IF_LK : 1, 0, "R3 R4");

      // R5: mid-band error while locked keeps lock
      run_cycle(4, 1, 0, "R5");

      // R2: unlock timing, wide RF up pulse
      rf_up = 1;
      repeat (RF_UL + 1) @(negedge clk);
      chk(rf_ok, 1, "R2", "rf_ok one tick before unlock width");
      @(negedge clk);
      chk(rf_ok, 0, "R2", "rf_ok at unlock width");
      repeat (2) @(negedge clk);
      rf_up = 0;
      repeat (4) @(negedge clk);
      rf_stb = 1; if_stb = 1; @(negedge clk); rf_stb = 0; if_stb = 0;
      repeat (3) @(negedge clk);
      model(rf_lk, rf_gd, 10, RF_UL, RF_LK, RF_N, 0);
      model(if_lk, if_gd, 0, IF_UL, IF_LK, IF_N, 0);
      push("R2");

      // R5: mid-band cycle empties the good run
      for (int c = 0; c < 5; c++) run_cycle(1, 1, 0, "R5");
      run_cycle(5, 1, 0, "R5");
      for (int c = 0; c < 10; c++) run_cycle(0, 0, 0, "R5 R3");

      // R9: down pulses on IF, down on RF, then up pulses on IF
      run_cycle(0, IF_UL, 0, "R9 R2");
      run_cycle(RF_UL + 1, 1, 1, "R9 R2");
      for (int c = 0; c < 3; c++) run_cycle(0, 2, 1, "R9 R4");

      // R7: RF unlocked into power save, good cycles ignored
      rf_ps = 1;
      repeat (2) @(negedge clk);
      push("R7");
      for (int c = 0; c < 12; c++) run_cycle(1, 0, 0, "R7");
      rf_ps = 0;
      repeat (2) @(negedge clk);
      push("R7");
      for (int c = 0; c < 10; c++) run_cycle(0, 0, 0, "R3");
      // R7: IF locked into power save, wide error ignored
      if_ps = 1;
      repeat (2) @(negedge clk);
      run_cycle(0, IF_UL + 2, 0, "R7");
      if_ps = 0;
      repeat (2) @(negedge clk);
      push("R7");

      // R8: monitor routing
      mon_en = 1;
      for (int s = 0; s < 4; s++) begin
         for (int v = 0; v < 2; v++) begin
            logic tv;
            tv = v[0];
            mon_sel = s[1:0];
            if_ref = (s == 0) ? tv : ~tv;
            rf_ref = (s == 1) ? tv : ~tv;
            if_fb  = (s == 2) ? tv : ~tv;
            rf_fb  = (s == 3) ? tv : ~tv;
            #1;
            chk(mon_pin, tv, "R8", "mon_pin routed");
            @(negedge clk);
         end
      end
      mon_en = 0;
      #1;
      chk(mon_pin, lock_all, "R8", "mon_pin back to lock");
      @(negedge clk);

      // R1: reset mid-run clears state and good runs
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      chk(rf_ok, 0, "R1", "rf_ok after reset");
      chk(if_ok, 0, "R1", "if_ok after reset");
      rf_lk = 0; rf_gd = 0; if_lk = 0; if_gd = 0;
      @(negedge clk);
      for (int c = 0; c < 3; c++) run_cycle(1, 1, 0, "R1 R4");

      while (exp_q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule